// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical address. The upper bits of the virtual address select a page and the lower bits give a byte offset. A small fully associative translation cache holds recent page-to-frame mappings with their permissions. When the cache holds the page, the unit answers in one cycle and makes no memory access. When it does not, the unit first compares the page number against a table length input. It then reads one entry from a single-level page table in memory, at the table base plus the page number, over a simple request/response port. A valid entry is installed in the cache and the unit reports the physical address. Otherwise it reports a fault code.

A client presents one request at a time. The unit holds `busy` high while a table walk is in flight and ignores requests until it has finished. Every accepted request ends in exactly one `done` pulse, which carries the physical address and a 2-bit fault code. A `flush` input models a context switch: it drops every cached mapping. Two free-running counters record how many lookups hit and how many missed in the cache.

Top module: `xlat_unit`

## Requirements
- R1: The page number is `req_vaddr[VA_W-1:OFF_W]` and the offset is `req_vaddr[OFF_W-1:0]`. A successful translation returns `{frame, offset}` with the offset unchanged. With 3 page bits and 5 offset bits, and page 5 mapped to frame 0, address 8'b10110100 gives 8'b00010100.
- R2: A request that hits in the cache raises `done` on the first clock edge after acceptance. `mem_req` stays low and `busy` stays low. `done` lasts one cycle.
- R3: A request that misses and is in range drives exactly one `mem_req` cycle, in the cycle after acceptance, with `mem_addr = tbl_base + page`. `done` rises on the edge that samples `mem_rvalid`. In a table entry, bits [FRAME_W-1:0] hold the frame, bit FRAME_W allows execute, bit FRAME_W+1 allows write, bit FRAME_W+2 allows read, and bit FRAME_W+3 is the valid bit.
- R4: A missing page with page number >= `tbl_len` finishes in one cycle with fault code 1 (bounds) and `done_paddr` 0. No memory request is issued.
- R5: A fetched entry whose valid bit is 0 ends with fault code 2 (invalid) and `done_paddr` 0. The entry is not cached, so a repeat access walks the table again.
- R6: Access codes are 0 read, 1 write, 2 execute. Code 3 is never permitted. An access the mapping does not allow ends with fault code 3 (protection) and `done_paddr` 0, on both the hit and the miss path. Fault code 0 means success.
- R7: A valid fetched entry is written into the lowest-numbered empty slot. If no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on every fill.
- R8: A cycle with `flush` high empties every slot, so no earlier mapping can hit afterwards. A request presented in the same cycle is treated as a miss.
- R9: `busy` is high from the cycle after a walk is accepted until its `done`. A request presented while `busy` is high is ignored: it produces no `done` and changes no counter.
- R10: `hit_count` increments once for each accepted request that hits. `miss_count` increments once for each accepted request that misses, including bounds faults.
- R11: After reset, `busy`, `done`, `mem_req` and both counters are 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | PAGE_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| flush | input | 1 | Context switch: empty the cache |
| tbl_base | input | MEM_AW | Page table base address |
| tbl_len | input | PAGE_W+1 | Number of pages covered by the table |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | FRAME_W+OFF_W | Physical address (0 on fault) |
| done_fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |
| mem_req | output | 1 | Page table read request |
| mem_addr | output | MEM_AW | Page table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | FRAME_W+4 | Page table entry |
| hit_count | output | CNT_W | Cache hits since reset |
| miss_count | output | CNT_W | Cache misses since reset |

## Verification
The stimulus mixes first-touch misses, repeat accesses that must hit, and pages just past the table length. This separates the cache path from the walk path and shows that the bounds test happens before any memory access. A run of distinct pages larger than the cache fills every slot and then forces evictions. Re-touching evicted and surviving pages shows whether the victim order follows the free-slot-then-pointer rule. Each access type is tried against entries that allow and forbid it. Invalid entries are touched twice, a stray request is held during a walk, and flushes are placed between accesses. Together these show whether faulting entries leak into the cache, whether the handshake drops requests while busy, and whether the cache is really emptied.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUNDS  = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_REQ  = 2'd1,
        WS_WAIT = 2'd2
    } wstate_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    // Access code 0 read, 1 write, 2 execute, 3 never allowed.
    function automatic logic perm_ok(perm_t p, logic [1:0] acc);
        case (acc)
            2'd0:    return p.rd;
            2'd1:    return p.wr;
            2'd2:    return p.ex;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int PAGE_W  = 3,
    parameter int FRAME_W = 3,
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output perm_t              lk_perm,
    input  logic               fill_en,
    input  logic [PAGE_W-1:0]  fill_page,
    input  logic [FRAME_W-1:0] fill_frame,
    input  perm_t              fill_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] slot_v;
    logic [ENTRIES-1:0] slot_match;
    logic [PAGE_W-1:0]  slot_page  [ENTRIES];
    logic [FRAME_W-1:0] slot_frame [ENTRIES];
    perm_t              slot_perm  [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   victim;
    logic               have_free;
    logic               do_fill;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign slot_match[g] = slot_v[g] && (slot_page[g] == lk_page);
        end
    endgenerate

    always_comb begin
        lk_hit   = |slot_match;
        lk_frame = '0;
        lk_perm  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (slot_match[i]) begin
                lk_frame = lk_frame | slot_frame[i];
                lk_perm  = lk_perm | slot_perm[i];
            end
        end
    end

    // Lowest empty slot first, round-robin pointer otherwise.
    always_comb begin
        victim    = rr_ptr;
        have_free = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!slot_v[i] && !have_free) begin
                victim    = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    assign do_fill = fill_en && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= '0;
            rr_ptr <= '0;
        end else if (flush) begin
            slot_v <= '0;
        end else if (do_fill) begin
            slot_v[victim] <= 1'b1;
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_fill) begin
            slot_page[victim]  <= fill_page;
            slot_frame[victim] <= fill_frame;
            slot_perm[victim]  <= fill_perm;
        end
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int PAGE_W  = 3,
    parameter int OFF_W   = 5,
    parameter int FRAME_W = 3,
    parameter int MEM_AW  = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [PAGE_W-1:0]          req_page,
    input  logic [OFF_W-1:0]           req_off,
    input  logic [1:0]                 req_acc,
    input  logic                       flush,
    input  logic                       tlb_hit,
    input  logic [FRAME_W-1:0]         tlb_frame,
    input  perm_t                      tlb_perm,
    input  logic [MEM_AW-1:0]          tbl_base,
    input  logic [PAGE_W:0]            tbl_len,
    input  logic                       mem_rvalid,
    input  logic [FRAME_W+3:0]         mem_rdata,
    output logic                       busy,
    output logic                       mem_req,
    output logic [MEM_AW-1:0]          mem_addr,
    output logic                       fill_en,
    output logic [PAGE_W-1:0]          fill_page,
    output logic [FRAME_W-1:0]         fill_frame,
    output perm_t                      fill_perm,
    output logic                       done,
    output logic [FRAME_W+OFF_W-1:0]   done_paddr,
    output fault_e                     done_fault,
    output logic                       hit_inc,
    output logic                       miss_inc
);
    localparam int PA_W = FRAME_W + OFF_W;

    wstate_e            state;
    logic [PAGE_W-1:0]  pend_page;
    logic [OFF_W-1:0]   pend_off;
    logic [1:0]         pend_acc;
    logic               accept;
    logic               use_hit;
    logic               out_of_range;
    logic               pte_valid;
    perm_t              pte_perm;
    logic [FRAME_W-1:0] pte_frame;

    assign pte_valid = mem_rdata[FRAME_W+3];
    assign pte_perm  = '{rd: mem_rdata[FRAME_W+2], wr: mem_rdata[FRAME_W+1], ex: mem_rdata[FRAME_W]};
    assign pte_frame = mem_rdata[FRAME_W-1:0];

    assign accept       = (state == WS_IDLE) && req_valid;
    assign use_hit      = tlb_hit && !flush;
    assign hit_inc      = accept && use_hit;
    assign miss_inc     = accept && !use_hit;
    assign out_of_range = {1'b0, req_page} >= tbl_len;

    assign busy       = (state != WS_IDLE);
    assign mem_req    = (state == WS_REQ);
    assign fill_en    = (state == WS_WAIT) && mem_rvalid && pte_valid;
    assign fill_page  = pend_page;
    assign fill_frame = pte_frame;
    assign fill_perm  = pte_perm;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WS_IDLE;
            done       <= 1'b0;
            done_paddr <= '0;
            done_fault <= FLT_NONE;
            mem_addr   <= '0;
            pend_page  <= '0;
            pend_off   <= '0;
            pend_acc   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (hit_inc) begin
                        done <= 1'b1;
                        if (perm_ok(tlb_perm, req_acc)) begin
                            done_paddr <= {tlb_frame, req_off};
                            done_fault <= FLT_NONE;
                        end else begin
                            done_paddr <= '0;
                            done_fault <= FLT_PROT;
                        end
                    end else if (miss_inc) begin
                        if (out_of_range) begin
                            done       <= 1'b1;
                            done_paddr <= '0;
                            done_fault <= FLT_BOUNDS;
                        end else begin
                            state     <= WS_REQ;
                            mem_addr  <= tbl_base + MEM_AW'(req_page);
                            pend_page <= req_page;
                            pend_off  <= req_off;
                            pend_acc  <= req_acc;
                        end
                    end
                end
                WS_REQ: state <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rvalid) begin
                        state <= WS_IDLE;
                        done  <= 1'b1;
                        if (!pte_valid) begin
                            done_paddr <= '0;
                            done_fault <= FLT_INVALID;
                        end else if (perm_ok(pte_perm, pend_acc)) begin
                            done_paddr <= PA_W'({pte_frame, pend_off});
                            done_fault <= FLT_NONE;
                        end else begin
                            done_paddr <= '0;
                            done_fault <= FLT_PROT;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlat_evcount.sv
module xlat_evcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int PAGE_W  = 3,
    parameter int OFF_W   = 5,
    parameter int FRAME_W = 3,
    parameter int ENTRIES = 4,
    parameter int MEM_AW  = 6,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [PAGE_W+OFF_W-1:0]  req_vaddr,
    input  logic [1:0]               req_acc,
    input  logic                     flush,
    input  logic [MEM_AW-1:0]        tbl_base,
    input  logic [PAGE_W:0]          tbl_len,
    output logic                     busy,
    output logic                     done,
    output logic [FRAME_W+OFF_W-1:0] done_paddr,
    output logic [1:0]               done_fault,
    output logic                     mem_req,
    output logic [MEM_AW-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [FRAME_W+3:0]       mem_rdata,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int VA_W = PAGE_W + OFF_W;

    logic [PAGE_W-1:0]  req_page;
    logic [OFF_W-1:0]   req_off;
    logic               tlb_hit;
    logic [FRAME_W-1:0] tlb_frame;
    perm_t              tlb_perm;
    logic               fill_en;
    logic [PAGE_W-1:0]  fill_page;
    logic [FRAME_W-1:0] fill_frame;
    perm_t              fill_perm;
    fault_e             w_fault;
    logic               hit_inc;
    logic               miss_inc;

    assign req_page   = req_vaddr[VA_W-1:OFF_W];
    assign req_off    = req_vaddr[OFF_W-1:0];
    assign done_fault = w_fault;

    xlat_tlb #(
        .PAGE_W (PAGE_W),
        .FRAME_W(FRAME_W),
        .ENTRIES(ENTRIES)
    ) tlb_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_page   (req_page),
        .lk_hit    (tlb_hit),
        .lk_frame  (tlb_frame),
        .lk_perm   (tlb_perm),
        .fill_en   (fill_en),
        .fill_page (fill_page),
        .fill_frame(fill_frame),
        .fill_perm (fill_perm)
    );

    xlat_walker #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .FRAME_W(FRAME_W),
        .MEM_AW (MEM_AW)
    ) walk_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_page  (req_page),
        .req_off   (req_off),
        .req_acc   (req_acc),
        .flush     (flush),
        .tlb_hit   (tlb_hit),
        .tlb_frame (tlb_frame),
        .tlb_perm  (tlb_perm),
        .tbl_base  (tbl_base),
        .tbl_len   (tbl_len),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .fill_en   (fill_en),
        .fill_page (fill_page),
        .fill_frame(fill_frame),
        .fill_perm (fill_perm),
        .done      (done),
        .done_paddr(done_paddr),
        .done_fault(w_fault),
        .hit_inc   (hit_inc),
        .miss_inc  (miss_inc)
    );

    xlat_evcount #(.CNT_W(CNT_W)) hits_i (
        .clk  (clk),
        .rst  (rst),
        .inc  (hit_inc),
        .count(hit_count)
    );

    xlat_evcount #(.CNT_W(CNT_W)) misses_i (
        .clk  (clk),
        .rst  (rst),
        .inc  (miss_inc),
        .count(miss_count)
    );

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
    parameter int PA_W  = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             busy,
    input logic             done,
    input logic [PA_W-1:0]  done_paddr,
    input logic [1:0]       done_fault,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    assert_req_in_walk_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_busy_from_req_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    assert_single_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_resp_completes_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rvalid && busy && !mem_req) |=> (done && !busy));

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault != 2'd0) |-> (done_paddr == '0));

    assert_one_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

bind xlat_unit xlat_unit_chk #(
    .PA_W (FRAME_W + OFF_W),
    .CNT_W(CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .done_paddr(done_paddr),
    .done_fault(done_fault),
    .mem_req   (mem_req),
    .mem_rvalid(mem_rvalid),
    .hit_count (hit_count),
    .miss_count(miss_count)
);

// File: tb/xlat_unit_tb_top.sv
module xlat_unit_tb_top;
    localparam int PAGE_W  = 3;
    localparam int OFF_W   = 5;
    localparam int FRAME_W = 3;
    localparam int ENTRIES = 4;
    localparam int MEM_AW  = 6;
    localparam int CNT_W   = 16;
    localparam int BASE    = 8;
    localparam int LEN     = 6;
    localparam int LAT     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [7:0]        req_vaddr = '0;
    logic [1:0]        req_acc   = '0;
    logic              flush     = 1'b0;
    logic [MEM_AW-1:0] tbl_base  = MEM_AW'(BASE);
    logic [PAGE_W:0]   tbl_len   = (PAGE_W + 1)'(LEN);
    logic              busy, done, mem_req;
    logic [7:0]        done_paddr;
    logic [1:0]        done_fault;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [6:0]        mem_rdata  = '0;
    logic [CNT_W-1:0]  hit_count, miss_count;

    xlat_unit #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
        .ENTRIES(ENTRIES), .MEM_AW(MEM_AW), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .flush(flush), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .busy(busy), .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Page table memory: [2:0] frame, [3] x, [4] w, [5] r, [6] valid.
    logic [6:0] pt_mem [64];

    // Behavioural reference of the cache contents.
    bit         m_v    [ENTRIES];
    int         m_page [ENTRIES];
    logic [6:0] m_pte  [ENTRIES];
    int m_rr = 0, m_hits = 0, m_miss = 0;
    int n_checks = 0, n_errors = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit allows(input logic [6:0] pte, input logic [1:0] acc);
        case (acc)
            2'd0:    return pte[5];
            2'd1:    return pte[4];
            2'd2:    return pte[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic xlat(input logic [7:0] va, input logic [1:0] acc, input string req,
                        input int want_pa = -1, input bit stray = 1'b0,
                        input logic [7:0] stray_va = 8'h00);
        int page = int'(va[7:5]);
        int hit_idx = -1;
        int exp_fault = 0;
        int exp_pa = 0;
        int addr = 0;
        int victim = -1;
        logic [6:0] pte;
        for (int i = 0; i < ENTRIES; i++)
            if (m_v[i] && m_page[i] == page) hit_idx = i;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit_idx >= 0) begin
            m_hits++;
            pte = m_pte[hit_idx];
            if (allows(pte, acc)) exp_pa = int'({pte[2:0], va[4:0]});
            else exp_fault = 3;
            chk(req, "hit issues no mem_req", int'(mem_req), 0);
            chk(req, "hit busy", int'(busy), 0);
        end else begin
            m_miss++;
            if (page >= LEN) begin
                exp_fault = 1;
                chk(req, "bounds mem_req", int'(mem_req), 0);
                chk(req, "bounds busy", int'(busy), 0);
            end else begin
                addr = BASE + page;
                chk(req, "miss busy", int'(busy), 1);
                chk(req, "miss mem_req", int'(mem_req), 1);
                chk(req, "miss mem_addr", int'(mem_addr), addr);
                chk(req, "miss early done", int'(done), 0);
                for (int k = 0; k < LAT; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk(req, "walk mem_req drop", int'(mem_req), 0);
                    chk(req, "walk done", int'(done), 0);
                    chk(req, "walk busy", int'(busy), 1);
                    if (stray && k == 0) begin
                        req_valid = 1'b1;
                        req_vaddr = stray_va;
                        req_acc   = 2'd0;
                    end else begin
                        req_valid = 1'b0;
                    end
                end
                req_valid  = 1'b0;
                pte        = pt_mem[addr];
                mem_rvalid = 1'b1;
                mem_rdata  = pte;
                @(posedge clk);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
                if (!pte[6]) begin
                    exp_fault = 2;
                end else begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!m_v[i] && victim < 0) victim = i;
                    if (victim < 0) victim = m_rr;
                    m_v[victim]    = 1'b1;
                    m_page[victim] = page;
                    m_pte[victim]  = pte;
                    m_rr = (m_rr + 1) % ENTRIES;
                    if (allows(pte, acc)) exp_pa = int'({pte[2:0], va[4:0]});
                    else exp_fault = 3;
                end
            end
        end
        chk(req, "done", int'(done), 1);
        chk(req, "fault code", int'(done_fault), exp_fault);
        chk(req, "paddr", int'(done_paddr), exp_pa);
        if (want_pa >= 0) chk(req, "paddr constant", int'(done_paddr), want_pa);
        chk("R10", "hit_count", int'(hit_count), m_hits);
        chk("R10", "miss_count", int'(miss_count), m_miss);
        @(posedge clk);
        @(negedge clk);
        chk(req, "done single cycle", int'(done), 0);
        chk(req, "idle busy", int'(busy), 0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
        chk("R8", "flush no done", int'(done), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) pt_mem[a] = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            m_v[i] = 1'b0; m_page[i] = 0; m_pte[i] = '0;
        end
        pt_mem[BASE + 0] = 7'b1110_010; // frame 2, read+write
        pt_mem[BASE + 1] = 7'b1100_100; // frame 4, read only
        pt_mem[BASE + 2] = 7'b0111_011; // invalid
        pt_mem[BASE + 3] = 7'b1111_111; // frame 7, all
        pt_mem[BASE + 4] = 7'b1001_101; // frame 5, execute only
        pt_mem[BASE + 5] = 7'b1111_000; // frame 0, all

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // r11_ reset state
        chk("R11", "reset busy", int'(busy), 0);
        chk("R11", "reset done", int'(done), 0);
        chk("R11", "reset mem_req", int'(mem_req), 0);
        chk("R11", "reset hit_count", int'(hit_count), 0);
        chk("R11", "reset miss_count", int'(miss_count), 0);

        xlat(8'b10110100, 2'd0, "R1", 8'b00010100);  // walk
        xlat(8'b10110100, 2'd0, "R2", 8'b00010100);  // hit
        xlat(8'b000_00111, 2'd1, "R3", 8'b010_00111);
        xlat(8'b000_11111, 2'd0, "R2", 8'b010_11111);
        xlat(8'b001_00001, 2'd1, "R6");               // miss, write denied
        xlat(8'b001_00010, 2'd0, "R6", 8'b100_00010);  // hit, read ok
        xlat(8'b001_00011, 2'd2, "R6");               // hit, exec denied
        xlat(8'b101_00000, 2'd3, "R6");               // code 3 denied
        xlat(8'b010_00000, 2'd0, "R5");
        xlat(8'b010_00001, 2'd0, "R5");               // walks again
        xlat(8'b110_00000, 2'd0, "R4");
        xlat(8'b111_11111, 2'd2, "R4");
        xlat(8'b011_00101, 2'd2, "R7", 8'b111_00101); // last free slot
        xlat(8'b100_00110, 2'd2, "R7", 8'b101_00110); // evicts pointer slot
        xlat(8'b101_00001, 2'd0, "R7");
        xlat(8'b000_00001, 2'd0, "R7");
        xlat(8'b011_00000, 2'd1, "R7");
        xlat(8'b100_00000, 2'd0, "R7");
        xlat(8'b001_01010, 2'd0, "R9", -1, 1'b1, 8'b011_00001);
        xlat(8'b011_00001, 2'd0, "R9");
        do_flush();
        xlat(8'b011_00001, 2'd0, "R8");
        xlat(8'b001_00000, 2'd0, "R8");
        do_flush();
        xlat(8'b101_10100, 2'd0, "R8", 8'b000_10100);
        xlat(8'b101_10100, 2'd2, "R2", 8'b000_10100);

        summary();
        $finish;
    end
endmodule